// File: doc/BRIEF.md
# Slow-Tick System Timer

This block is a memory-mapped system timer that advances on a slow-tick enable. The enable pulses 32768 times per second, and everything runs in one clock domain. It holds three parts. The first is a 20-bit free-running count, advanced by a programmable prescaler. The second is an alarm that fires when that count steps onto an absolute target value. The third is an independent interval timer that flags every N slow ticks.

Four event flags live in a status word. Reading the status word returns it and clears it. Software masks the flags with separate write-one-to-set and write-one-to-clear registers. A single level interrupt is raised while any flag is both pending and enabled.

A common use is a clock source plus a tick generator for an operating system. For periodic ticks, software programs the interval period. For one-shot events, software writes the alarm with the current count plus a delta. The delta must be at least 2, because a target equal to the present count only matches after a full wrap.

Top module: `slow_timer`

## Requirements
- R1: The count register (word address 0x1C) resets to 0. It reads the current 20-bit count at any time and rises by exactly 1 on each prescaled increment, wrapping to 0.
- R2: The prescaler register (0x04) is 16 bits wide and resets to 32768. A value N makes one count increment every N slow ticks, and 0 stands for 65536. Writing it restarts the prescale phase, so with N=1 every tick increments the count.
- R3: The alarm register (0x18) holds an absolute 20-bit target. Status bit 3 sets in the cycle the count steps onto that target, and not on earlier ticks.
- R4: An alarm target equal to the count at the time of writing does not match on the following increments; it waits for the count to come round again.
- R5: The period register (0x00) is 16 bits wide, with 0 standing for 65536. Status bit 0 sets once every period slow ticks, independently of the alarm. Writing the register restarts the interval from the new value.
- R6: The status register (0x08) has bit 0 for period expiry, bit 1 for watchdog overflow (always 0 here), bit 2 for count increment and bit 3 for alarm. A read returns the pending bits and clears them.
- R7: An event arriving in the same cycle as a status read is kept and shows on the next read.
- R8: Writing ones to 0x0C sets mask bits, writing ones to 0x10 clears them, and 0x14 reads the mask back. The mask resets to 0.
- R9: `irq` is high exactly while some status bit and its mask bit are both set, and it falls when a status read clears them.
- R10: Status bit 2 sets on every prescaled count increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle slow-tick enable |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 20 | Write data, as wide as the widest writable field |
| bus_rd | input | 1 | Read strobe; a status read clears the status |
| bus_rdata | output | 32 | Read data for the addressed register, valid while bus_rd is high |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume the following about the inputs:
- `tick_en` is a single-cycle pulse.
- The bus presents at most one access per cycle.
- Accesses are word aligned.
- A target register is not rewritten in the cycle its own event fires.

The stimulus drives each access for exactly one cycle, on its own, and uses only aligned addresses. It separates ticks from accesses by at least one cycle. The single exception is the deliberate case where a tick and a status read share a cycle.

// File: rtl/st_pkg.sv
package st_pkg;
    // status / mask bit positions
    localparam int STS_PIT  = 0;
    localparam int STS_WDG  = 1;
    localparam int STS_INC  = 2;
    localparam int STS_ALM  = 3;
    localparam int NUM_STS  = 4;

    // word indices (byte address / 4)
    localparam int REG_PERIOD = 0;
    localparam int REG_PRESC  = 1;
    localparam int REG_STATUS = 2;
    localparam int REG_IEN    = 3;
    localparam int REG_IDIS   = 4;
    localparam int REG_MASK   = 5;
    localparam int REG_ALARM  = 6;
    localparam int REG_COUNT  = 7;
endpackage

// File: rtl/st_rtc.sv
module st_rtc #(
    parameter int CNT_W   = 20,
    parameter int PRE_W   = 16,
    parameter int PRE_RST = 32768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             presc_wr,
    input  logic [PRE_W-1:0] presc_wdata,
    input  logic             alarm_wr,
    input  logic [CNT_W-1:0] alarm_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [PRE_W-1:0] presc,
    output logic [CNT_W-1:0] alarm,
    output logic             inc_evt,
    output logic             alm_evt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] phase;
        logic [PRE_W-1:0] presc;
        logic [CNT_W-1:0] alarm;
    } rtc_t;

    rtc_t st_d, st_q;
    logic [PRE_W:0]   presc_eff;
    logic [CNT_W-1:0] cnt_next;
    logic             last_phase;

    always_comb begin
        presc_eff  = {(st_q.presc == '0), st_q.presc};
        last_phase = tick_en && ({1'b0, st_q.phase} == presc_eff - 1'b1);
        cnt_next   = st_q.cnt + 1'b1;
        inc_evt    = last_phase;
        alm_evt    = last_phase && (cnt_next == st_q.alarm);

        st_d = st_q;
        if (tick_en) begin
            if (last_phase) begin
                st_d.phase = '0;
                st_d.cnt   = cnt_next;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
        if (presc_wr) begin
            st_d.presc = presc_wdata;
            st_d.phase = '0;
        end
        if (alarm_wr) begin
            st_d.alarm = alarm_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.phase <= '0;
            st_q.presc <= PRE_W'(PRE_RST);
            st_q.alarm <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt   = st_q.cnt;
    assign presc = st_q.presc;
    assign alarm = st_q.alarm;

    // R1: the count only ever moves by one step
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != $past(st_q.cnt)) |-> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));

    // R3: an alarm event lands the count on the target
    a_r3_alarm_hit: assert property (@(posedge clk) disable iff (!rst_n)
        alm_evt |=> (st_q.cnt == $past(st_q.alarm)));
endmodule

// File: rtl/st_pit.sv
module st_pit #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             per_wr,
    input  logic [PRE_W-1:0] per_wdata,
    output logic [PRE_W-1:0] period,
    output logic             pit_evt
);
    typedef struct packed {
        logic [PRE_W-1:0] per;
        logic [PRE_W:0]   left;
    } pit_t;

    pit_t st_d, st_q;
    logic [PRE_W:0] per_eff;
    logic [PRE_W:0] wr_eff;

    always_comb begin
        per_eff = {(st_q.per == '0), st_q.per};
        wr_eff  = {(per_wdata == '0), per_wdata};
        pit_evt = tick_en && (st_q.left == (PRE_W+1)'(1));

        st_d = st_q;
        if (tick_en) begin
            st_d.left = pit_evt ? per_eff : st_q.left - 1'b1;
        end
        if (per_wr) begin
            st_d.per  = per_wdata;
            st_d.left = wr_eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.per  <= '0;
            st_q.left <= {1'b1, {PRE_W{1'b0}}};
        end else begin
            st_q <= st_d;
        end
    end

    assign period = st_q.per;

    // R5: after an expiry the interval reloads to the full period
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (pit_evt && !per_wr) |=> (st_q.left == {(st_q.per == '0), st_q.per}));
endmodule

// File: rtl/st_irq.sv
module st_irq #(
    parameter int NUM_STS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_STS-1:0] events,
    input  logic               sts_rd,
    input  logic               ien_wr,
    input  logic               idis_wr,
    input  logic [NUM_STS-1:0] wdata,
    output logic [NUM_STS-1:0] sts,
    output logic [NUM_STS-1:0] mask,
    output logic               irq
);
    typedef struct packed {
        logic [NUM_STS-1:0] sts;
        logic [NUM_STS-1:0] mask;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sts = (sts_rd ? '0 : st_q.sts) | events;
        if (ien_wr) begin
            st_d.mask = st_q.mask | wdata;
        end else if (idis_wr) begin
            st_d.mask = st_q.mask & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts  = st_q.sts;
    assign mask = st_q.mask;
    assign irq  = |(st_q.sts & st_q.mask);

    // R6: a read with no new event leaves status empty
    a_r6_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && (events == '0)) |=> (st_q.sts == '0));

    // R7: any event is pending the next cycle even across a read
    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (events != '0) |=> ((st_q.sts & $past(events)) == $past(events)));

    // R8: enable writes set the written mask bits
    a_r8_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ien_wr |=> ((st_q.mask & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/slow_timer.sv
module slow_timer #(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 20,
    parameter int PRE_W   = 16,
    parameter int PRE_RST = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    import st_pkg::*;

    localparam int WORD_LSB = 2;
    localparam int SEL_W    = ADDR_W - WORD_LSB;

    logic [SEL_W-1:0]   word;
    logic               aligned;
    logic [7:0]         hit;
    logic [CNT_W-1:0]   cnt, alarm;
    logic [PRE_W-1:0]   presc, period;
    logic               inc_evt, alm_evt, pit_evt;
    logic [NUM_STS-1:0] events, sts, mask;

    assign word    = bus_addr[ADDR_W-1:WORD_LSB];
    assign aligned = (bus_addr[WORD_LSB-1:0] == '0);

    for (genvar g = 0; g < 8; g++) begin : g_dec
        assign hit[g] = aligned && (int'(word) == g);
    end

    st_rtc #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_rtc (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .presc_wr    (bus_wr && hit[REG_PRESC]),
        .presc_wdata (bus_wdata[PRE_W-1:0]),
        .alarm_wr    (bus_wr && hit[REG_ALARM]),
        .alarm_wdata (bus_wdata),
        .cnt         (cnt),
        .presc       (presc),
        .alarm       (alarm),
        .inc_evt     (inc_evt),
        .alm_evt     (alm_evt)
    );

    st_pit #(.PRE_W(PRE_W)) u_pit (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .per_wr    (bus_wr && hit[REG_PERIOD]),
        .per_wdata (bus_wdata[PRE_W-1:0]),
        .period    (period),
        .pit_evt   (pit_evt)
    );

    always_comb begin
        events          = '0;
        events[STS_PIT] = pit_evt;
        events[STS_WDG] = 1'b0;
        events[STS_INC] = inc_evt;
        events[STS_ALM] = alm_evt;
    end

    st_irq #(.NUM_STS(NUM_STS)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .events  (events),
        .sts_rd  (bus_rd && hit[REG_STATUS]),
        .ien_wr  (bus_wr && hit[REG_IEN]),
        .idis_wr (bus_wr && hit[REG_IDIS]),
        .wdata   (bus_wdata[NUM_STS-1:0]),
        .sts     (sts),
        .mask    (mask),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit[REG_PERIOD]) bus_rdata = DATA_W'(period);
        if (hit[REG_PRESC])  bus_rdata = DATA_W'(presc);
        if (hit[REG_STATUS]) bus_rdata = DATA_W'(sts);
        if (hit[REG_MASK])   bus_rdata = DATA_W'(mask);
        if (hit[REG_ALARM])  bus_rdata = DATA_W'(alarm);
        if (hit[REG_COUNT])  bus_rdata = DATA_W'(cnt);
    end
endmodule

// File: tb/tb_slow_timer.sv
module tb_slow_timer;
    localparam int A_PER = 'h00, A_PRE = 'h04, A_STS = 'h08, A_IEN = 'h0C;
    localparam int A_IDIS = 'h10, A_MSK = 'h14, A_ALM = 'h18, A_CNT = 'h1C;

    logic        clk = 0, rst_n = 0, tick_en = 0, bus_wr = 0, bus_rd = 0;
    logic [4:0]  bus_addr = '0;
    logic [19:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    // reference model state
    int cnt_m = 0, presc_m = 32768, phase_m = 0, per_m = 0, left_m = 65536, alarm_m = 0;
    logic [3:0] sts_m = '0;

    slow_timer dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq(irq));

    always #5 clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compares read data against the scoreboard queue
    always @(negedge clk) begin
        #2;
        if (bus_rd && exp_q.size() > 0) check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end

    function automatic void model_tick();
        int pe = (presc_m == 0) ? 65536 : presc_m;
        phase_m++;
        if (phase_m == pe) begin
            phase_m = 0;
            cnt_m = (cnt_m + 1) % (1 << 20);
            sts_m[2] = 1'b1;
            if (cnt_m == alarm_m) sts_m[3] = 1'b1;
        end
        left_m--;
        if (left_m == 0) begin
            left_m = (per_m == 0) ? 65536 : per_m;
            sts_m[0] = 1'b1;
        end
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1; model_tick();
            @(negedge clk); tick_en = 0;
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); bus_addr = 5'(a); bus_wdata = 20'(d); bus_wr = 1;
        @(negedge clk); bus_wr = 0;
        if (a == A_PRE) begin presc_m = d; phase_m = 0; end
        if (a == A_PER) begin per_m = d; left_m = (d == 0) ? 65536 : d; end
        if (a == A_ALM) alarm_m = d;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); bus_addr = 5'(a); bus_rd = 1;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic rd_sts(input string tag);
        logic [31:0] e = 32'(sts_m);
        sts_m = '0;
        rd(A_STS, e, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state
        check(32'(irq), 0, "R9 irq reset");
        rd(A_PER, 0, "R5 period reset");
        rd(A_PRE, 32768, "R2 prescaler reset");
        rd(A_STS, 0, "R6 status reset");
        rd(A_MSK, 0, "R8 mask reset");
        rd(A_CNT, 0, "R1 count reset");
        // default prescaler: few ticks do not increment
        tick(3);
        rd(A_CNT, 0, "R2 slow prescale holds count");
        // prescaler 1: every tick counts
        wr(A_PRE, 1);
        tick(5);
        rd(A_CNT, 32'(cnt_m), "R1 count after 5 ticks");
        rd_sts("R10 increment bit");
        rd_sts("R6 cleared by read");
        // prescaler 3
        wr(A_PRE, 3);
        tick(7);
        rd(A_CNT, 32'(cnt_m), "R2 prescale by 3");
        wr(A_PRE, 1);
        rd_sts("R6 clear");
        // interval timer
        wr(A_PER, 4);
        tick(9);
        rd_sts("R5 two expiries");
        wr(A_PER, 4);
        tick(3);
        rd_sts("R5 restart, no expiry yet");
        tick(1);
        rd_sts("R5 expiry after restart");
        wr(A_PER, 0);
        // alarm at count+2
        wr(A_ALM, cnt_m + 2);
        tick(1);
        rd_sts("R3 alarm not yet");
        tick(1);
        check(32'(sts_m[3]), 1, "R3 model expects alarm");
        rd_sts("R3 alarm fired");
        // alarm equal to current count
        wr(A_ALM, cnt_m);
        tick(4);
        rd_sts("R4 no match at current count");
        // event in same cycle as status read
        rd_sts("R6 clear");
        exp_q.push_back(32'(sts_m)); tag_q.push_back("R7 read during tick");
        sts_m = '0;
        @(negedge clk); bus_addr = 5'(A_STS); bus_rd = 1; tick_en = 1; model_tick();
        @(negedge clk); bus_rd = 0; tick_en = 0;
        rd_sts("R7 event kept");
        // mask and irq
        wr(A_IEN, 'h8);
        rd(A_MSK, 'h8, "R8 enable");
        check(32'(irq), 0, "R9 no pending");
        wr(A_ALM, cnt_m + 2);
        tick(2);
        check(32'(irq), 1, "R9 irq on alarm");
        rd_sts("R9 status read");
        check(32'(irq), 0, "R9 irq drops after read");
        wr(A_IEN, 'h1);
        wr(A_IDIS, 'h8);
        rd(A_MSK, 'h1, "R8 disable");
        wr(A_ALM, cnt_m + 1);
        tick(1);
        check(32'(irq), 0, "R8 disabled alarm masked");
        check(32'(sts_m & 4'h2), 0, "R6 watchdog bit zero");
        rd_sts("R6 alarm+inc pending");
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule